// File: doc/BRIEF.md
# Oscillator Trim Startup Calibrator

This controller runs a single search at power-up. It finds a setting for the binary-weighted trim capacitor bank of a ring oscillator that puts the beat count from a beat frequency detector inside a target window. The default window is 200 to 500. The block drives a 6-bit trim code, where bit k selects a capacitor of weight 2^k. A larger code moves the two oscillator frequencies closer together, so the beat count rises.

A pulse on `start` while the block is idle begins the search. The controller loads the initial code and waits for fresh counts. It discards the first count after every change of the code, then evaluates the next one. A count below the lower limit makes the code step up by one. A count above the upper limit makes it step down by one. A count inside the limits locks the code, and the block raises `done`. The block gives up and raises `fail` in two cases: the needed step would run past code 0 or the largest code, or the step budget is used up. Once either result is reached, the block freezes until reset. It copies the final code into a scan output register.

Top module: `trim_cal_ctrl`

## Requirements
- R1: After reset, `trim_code` equals the initial code (0 by default), and `done`, `fail` and `scan_valid` are 0.
- R2: While idle, `cnt_valid` pulses are ignored: the code does not change and neither `done` nor `fail` rises until `start` has been pulsed.
- R3: After `start` and after each change of the code, the first valid count is discarded. Only a later count is evaluated.
- R4: An evaluated count with `lo_limit <= count <= hi_limit` (both bounds inclusive) locks the current code and raises `done`.
- R5: An evaluated count below `lo_limit` increases `trim_code` by exactly one.
- R6: An evaluated count above `hi_limit` decreases `trim_code` by exactly one.
- R7: A count above the window while the code is 0 raises `fail`, and the code stays at 0.
- R8: A count below the window while the code is all ones (63) raises `fail`, and the code stays at 63.
- R9: At most 64 adjustments are made. An out-of-range evaluation after the 64th adjustment raises `fail` and does not change the code.
- R10: Once `done` or `fail` is high, it stays high until reset. The two are never high together, and further `start` pulses or counts leave `trim_code` unchanged.
- R11: `scan_code` reads 0 and `scan_valid` is 0 until `done` or `fail` rises. From then on, `scan_valid` is 1 and `scan_code` equals the final `trim_code`.
- R12: The window limits are taken from the `lo_limit` and `hi_limit` inputs at evaluation time, not from fixed constants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the one-time search when idle |
| cnt_valid | input | 1 | Strobe marking a new beat count |
| cnt_value | input | 12 | Beat count from the detector |
| lo_limit | input | 12 | Lowest acceptable count (inclusive) |
| hi_limit | input | 12 | Highest acceptable count (inclusive) |
| trim_code | output | 6 | Binary-weighted capacitor select |
| done | output | 1 | Search ended with a code in the window |
| fail | output | 1 | Search ended without success |
| scan_code | output | 6 | Frozen final code for scan-out |
| scan_valid | output | 1 | `scan_code` holds a final result |

## Verification
The bench places counts exactly on 199, 200, 500 and 501. A design that made either bound exclusive, or swapped the step direction, would lock or step at the wrong edge. It checks that a single count right after `start` or after a code change does not lock the code. A design that skipped the discard would report `done` one count too early. It drives the code into both ends of its range: a design without edge guards would wrap 0 to 63 or 63 to 0 instead of failing. It also alternates low and high counts to use up the adjustment budget. An off-by-one in that budget would fail one adjustment early or late.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
   typedef enum logic [2:0] {
      CAL_IDLE,
      CAL_SETTLE,
      CAL_MEASURE,
      CAL_CHECK,
      CAL_ADJUST,
      CAL_LOCKED,
      CAL_FAIL
   } cal_state_e;

   typedef enum logic [1:0] {
      VERDICT_IN   = 2'd0,
      VERDICT_LOW  = 2'd1,
      VERDICT_HIGH = 2'd2
   } verdict_e;
endpackage

// File: rtl/window_cmp.sv
module window_cmp
   import trim_cal_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0] sample,
   input  logic [CNT_W-1:0] lo_lim,
   input  logic [CNT_W-1:0] hi_lim,
   output verdict_e         verdict
);
   always_comb begin
      if (sample < lo_lim)
         verdict = VERDICT_LOW;
      else if (sample > hi_lim)
         verdict = VERDICT_HIGH;
      else
         verdict = VERDICT_IN;
   end
endmodule

// File: rtl/trim_stepper.sv
module trim_stepper #(
   parameter int TRIM_W = 6
) (
   input  logic [TRIM_W-1:0] cur,
   input  logic              step_up,
   output logic [TRIM_W-1:0] nxt,
   output logic              at_edge
);
   localparam logic [TRIM_W-1:0] ONE = TRIM_W'(1);

   always_comb begin
      if (step_up) begin
         at_edge = &cur;
         nxt     = cur + ONE;
      end else begin
         at_edge = ~|cur;
         nxt     = cur - ONE;
      end
   end
endmodule

// File: rtl/settle_gate.sv
module settle_gate #(
   parameter int DISCARD = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic cnt_valid,
   output logic settled
);
   generate
      if (DISCARD == 0) begin : g_nodiscard
         assign settled = 1'b1;
      end else begin : g_discard
         localparam int DW = $clog2(DISCARD + 1);
         localparam logic [DW-1:0] LIMIT = DW'(DISCARD);
         logic [DW-1:0] seen;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               seen <= '0;
            else if (clear)
               seen <= '0;
            else if (cnt_valid && (seen != LIMIT))
               seen <= seen + DW'(1);
         end

         assign settled = (seen == LIMIT);
      end
   endgenerate
endmodule

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
   import trim_cal_pkg::*;
#(
   parameter int TRIM_W    = 6,
   parameter int CNT_W     = 12,
   parameter int INIT_TRIM = 0,
   parameter int DISCARD   = 1,
   parameter int MAX_ADJ   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cnt_valid,
   input  logic [CNT_W-1:0]  cnt_value,
   input  logic [CNT_W-1:0]  lo_limit,
   input  logic [CNT_W-1:0]  hi_limit,
   output logic [TRIM_W-1:0] trim_code,
   output logic              done,
   output logic              fail,
   output logic [TRIM_W-1:0] scan_code,
   output logic              scan_valid
);
   localparam int AW = $clog2(MAX_ADJ + 1);
   localparam logic [AW-1:0]     ADJ_LIMIT = AW'(MAX_ADJ);
   localparam logic [TRIM_W-1:0] TRIM_INIT = TRIM_W'(INIT_TRIM);

   generate
      if (TRIM_W < 1 || TRIM_W > 16) begin : g_bad_trim_w
         $error("TRIM_W out of range");
      end
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("CNT_W too small");
      end
      if (INIT_TRIM < 0 || INIT_TRIM >= (1 << TRIM_W)) begin : g_bad_init
         $error("INIT_TRIM does not fit TRIM_W");
      end
      if (DISCARD < 0 || DISCARD > 255) begin : g_bad_discard
         $error("DISCARD out of range");
      end
      if (MAX_ADJ < 1) begin : g_bad_max_adj
         $error("MAX_ADJ must be positive");
      end
   endgenerate

   cal_state_e         state;
   logic [TRIM_W-1:0]  trim_r;
   logic [CNT_W-1:0]   sample_r;
   logic [AW-1:0]      adj_cnt;
   logic               dir_up_r;
   logic [TRIM_W-1:0]  scan_r;

   verdict_e           verdict;
   logic               settled;
   logic               step_up;
   logic [TRIM_W-1:0]  trim_nxt;
   logic               trim_at_edge;

   window_cmp #(.CNT_W(CNT_W)) u_cmp (
      .sample  (sample_r),
      .lo_lim  (lo_limit),
      .hi_lim  (hi_limit),
      .verdict (verdict)
   );

   assign step_up = (state == CAL_CHECK) ? (verdict == VERDICT_LOW) : dir_up_r;

   trim_stepper #(.TRIM_W(TRIM_W)) u_step (
      .cur     (trim_r),
      .step_up (step_up),
      .nxt     (trim_nxt),
      .at_edge (trim_at_edge)
   );

   settle_gate #(.DISCARD(DISCARD)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state != CAL_SETTLE),
      .cnt_valid (cnt_valid),
      .settled   (settled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= CAL_IDLE;
         trim_r   <= TRIM_INIT;
         sample_r <= '0;
         adj_cnt  <= '0;
         dir_up_r <= 1'b0;
         scan_r   <= '0;
      end else begin
         case (state)
            CAL_IDLE: begin
               if (start) begin
                  trim_r  <= TRIM_INIT;
                  adj_cnt <= '0;
                  state   <= CAL_SETTLE;
               end
            end
            CAL_SETTLE: begin
               if (settled) begin
                  if (cnt_valid) begin
                     sample_r <= cnt_value;
                     state    <= CAL_CHECK;
                  end else begin
                     state    <= CAL_MEASURE;
                  end
               end
            end
            CAL_MEASURE: begin
               if (cnt_valid) begin
                  sample_r <= cnt_value;
                  state    <= CAL_CHECK;
               end
            end
            CAL_CHECK: begin
               if (verdict == VERDICT_IN) begin
                  scan_r <= trim_r;
                  state  <= CAL_LOCKED;
               end else if (trim_at_edge || (adj_cnt == ADJ_LIMIT)) begin
                  scan_r <= trim_r;
                  state  <= CAL_FAIL;
               end else begin
                  dir_up_r <= (verdict == VERDICT_LOW);
                  state    <= CAL_ADJUST;
               end
            end
            CAL_ADJUST: begin
               trim_r  <= trim_nxt;
               adj_cnt <= adj_cnt + AW'(1);
               state   <= CAL_SETTLE;
            end
            CAL_LOCKED: state <= CAL_LOCKED;
            CAL_FAIL:   state <= CAL_FAIL;
            default:    state <= CAL_IDLE;
         endcase
      end
   end

   assign trim_code  = trim_r;
   assign done       = (state == CAL_LOCKED);
   assign fail       = (state == CAL_FAIL);
   assign scan_valid = done | fail;
   assign scan_code  = scan_r;
endmodule

// File: rtl/trim_cal_checker.sv
module trim_cal_checker #(
   parameter int TRIM_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TRIM_W-1:0] trim_code,
   input logic              done,
   input logic              fail,
   input logic [TRIM_W-1:0] scan_code,
   input logic              scan_valid
);
   assert_done_fail_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(trim_code)));

   assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> (fail && $stable(trim_code)));

   assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_code != $past(trim_code)) |->
         ((trim_code == $past(trim_code) + TRIM_W'(1)) ||
          (trim_code == $past(trim_code) - TRIM_W'(1))));

   assert_scan_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
      scan_valid |-> (scan_code == trim_code));

   assert_scan_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_valid |-> (scan_code == '0));
endmodule

bind trim_cal_ctrl trim_cal_checker #(.TRIM_W(TRIM_W)) u_trim_cal_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .trim_code  (trim_code),
   .done       (done),
   .fail       (fail),
   .scan_code  (scan_code),
   .scan_valid (scan_valid)
);

// File: tb/trim_cal_ctrl_test.sv
`timescale 1ns/1ps
module trim_cal_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cnt_valid = 1'b0;
   logic [11:0] cnt_value = '0;
   logic [11:0] lo_limit = 12'd200;
   logic [11:0] hi_limit = 12'd500;
   logic [5:0]  trim_code;
   logic        done;
   logic        fail;
   logic [5:0]  scan_code;
   logic        scan_valid;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   trim_cal_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cnt_valid  (cnt_valid),
      .cnt_value  (cnt_value),
      .lo_limit   (lo_limit),
      .hi_limit   (hi_limit),
      .trim_code  (trim_code),
      .done       (done),
      .fail       (fail),
      .scan_code  (scan_code),
      .scan_valid (scan_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n     = 1'b0;
      start     = 1'b0;
      cnt_valid = 1'b0;
      lo_limit  = 12'd200;
      hi_limit  = 12'd500;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic give(input int v);
      @(negedge clk);
      cnt_valid = 1'b1;
      cnt_value = 12'(v);
      @(negedge clk);
      cnt_valid = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // one evaluated count: discarded count first, then the real one
   task automatic eval(input int v);
      give(350);
      give(v);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 trim", trim_code, 0);
      chk("R1 done", done, 0);
      chk("R1 fail", fail, 0);
      chk("R11 scan_valid", scan_valid, 0);
      chk("R11 scan_code", scan_code, 0);
   endtask

   task automatic t_no_start();
      do_reset();
      give(300); give(100); give(300);
      chk("R2 done", done, 0);
      chk("R2 trim", trim_code, 0);
   endtask

   task automatic t_discard();
      do_reset();
      pulse_start();
      give(300);
      chk("R3 first count ignored", done, 0);
      give(300);
      chk("R4 locked", done, 1);
      chk("R11 scan_valid", scan_valid, 1);
      chk("R11 scan_code", scan_code, 0);
   endtask

   task automatic t_climb();
      do_reset();
      pulse_start();
      eval(199);
      chk("R5 step up at 199", trim_code, 1);
      chk("R5 not done", done, 0);
      give(350);
      chk("R3 discard after change", done, 0);
      give(150);
      chk("R5 second step", trim_code, 2);
      eval(200);
      chk("R4 lower bound inclusive", done, 1);
      chk("R11 scan code", scan_code, 2);
   endtask

   task automatic t_descend();
      do_reset();
      pulse_start();
      eval(10); eval(10); eval(10);
      chk("R5 climbed", trim_code, 3);
      eval(501);
      chk("R6 step down at 501", trim_code, 2);
      eval(500);
      chk("R4 upper bound inclusive", done, 1);
      chk("R4 locked code", trim_code, 2);
   endtask

   task automatic t_floor();
      do_reset();
      pulse_start();
      eval(600);
      chk("R7 fail", fail, 1);
      chk("R7 trim", trim_code, 0);
      chk("R10 done low", done, 0);
      chk("R11 scan_valid", scan_valid, 1);
   endtask

   task automatic t_ceiling();
      do_reset();
      pulse_start();
      for (int i = 0; i < 63; i++) eval(50);
      chk("R8 reached top", trim_code, 63);
      chk("R8 no fail yet", fail, 0);
      eval(50);
      chk("R8 fail", fail, 1);
      chk("R8 trim held", trim_code, 63);
      chk("R11 scan code", scan_code, 63);
   endtask

   task automatic t_budget();
      do_reset();
      pulse_start();
      for (int i = 0; i < 32; i++) begin
         eval(50);
         eval(900);
      end
      chk("R9 after 64 steps no fail", fail, 0);
      chk("R9 trim", trim_code, 0);
      eval(50);
      chk("R9 fail on 65th", fail, 1);
      chk("R9 trim unchanged", trim_code, 0);
   endtask

   task automatic t_hold();
      do_reset();
      pulse_start();
      eval(100);
      eval(300);
      chk("R10 locked", done, 1);
      pulse_start();
      eval(100); eval(900);
      chk("R10 trim frozen", trim_code, 1);
      chk("R10 done held", done, 1);
      chk("R10 fail low", fail, 0);
   endtask

   task automatic t_window();
      do_reset();
      lo_limit = 12'd1000;
      hi_limit = 12'd1100;
      pulse_start();
      eval(500);
      chk("R12 500 below custom window", trim_code, 1);
      chk("R12 not done", done, 0);
      eval(1050);
      chk("R12 lock in custom window", done, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_no_start();
      t_discard();
      t_climb();
      t_descend();
      t_floor();
      t_ceiling();
      t_budget();
      t_hold();
      t_window();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule